// File: doc/BRIEF.md
# Buffer-Completion Timestamp Capture

This block keeps a free-running cycle counter that mirrors the low bits of the processor's cycle count. It also records the counter value at the moment the final sample of a DMA buffer is driven onto the serial data pin. Software can load the counter so that it equals the processor count. From then on the counter advances once per core clock while the global count-enable condition holds, and it holds its value while that condition is false.

When the serial path reports that the last sample of a buffer has left the pin, the counter value is latched into a read-only timestamp register. A buffer-empty event is raised in the same cycle that the new timestamp becomes visible. An interrupt handler triggered by that event therefore always reads the value for the buffer that just finished. Power-down, whether global or block-level, has no effect on the counter, so alignment with the processor count survives sleep.

Top module: `buf_done_stamp`

## Requirements
- R1: After reset the counter, `stamp` and `buf_empty` are all zero.
- R2: With `cnt_en`=1 and no load, the counter rises by exactly one per clock edge.
- R3: With `cnt_en`=0 and no load, the counter holds its value.
- R4: A `load_req` sampled at an edge sets the counter to `load_val`, whatever `cnt_en` is. Load wins over increment, so the counter is `load_val` and not `load_val`+1.
- R5: A `last_smp` sampled at an edge copies the counter value present at that edge into `stamp`, visible after the edge. If a load occurs at the same edge, the value captured is the one before the load.
- R6: `stamp` changes only on a capture. No input other than `last_smp` writes it.
- R7: `buf_empty` is high for exactly one cycle after each captured edge, in the same cycle that `stamp` shows the new value.
- R8: `pwr_down` has no effect on the counter, the capture or the event.
- R9: The counter wraps from 0xFFFFFFFF to 0 and sets no flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cnt_en | input | 1 | Global cycle-count enable |
| load_req | input | 1 | Load the counter with `load_val` |
| load_val | input | 32 | Value to load, normally the processor cycle count |
| last_smp | input | 1 | Strobe: last sample of a buffer has left the serial pin |
| pwr_down | input | 1 | Power-down request (global or block-level) |
| stamp | output | 32 | Read-only captured timestamp |
| buf_empty | output | 1 | One-cycle buffer-empty event |

## Verification
A counter that drifts, misses an increment or ignores a load shows only through the timestamp. It shows at the next capture, as a `stamp` offset from the expected load-plus-elapsed-cycles value. The bench therefore pairs each counting scenario with a capture at a known cycle distance. A misaligned event shows at once: the cycle with `buf_empty` high would carry a stale `stamp`. Wrap and power-down faults show at the first capture taken after the boundary or while power-down is asserted.

// File: rtl/buf_done_stamp.sv
module buf_done_stamp #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cnt_en,
  input  logic         load_req,
  input  logic [W-1:0] load_val,
  input  logic         last_smp,
  input  logic         pwr_down,
  output logic [W-1:0] stamp,
  output logic         buf_empty
);

  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_nx;
  logic         unused_pd;

  assign unused_pd = pwr_down;
  assign cnt_nx = load_req ? load_val : cnt_q + W'(cnt_en);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q     <= '0;
      stamp     <= '0;
      buf_empty <= 1'b0;
    end else begin
      cnt_q     <= cnt_nx;
      buf_empty <= last_smp;
      if (last_smp) stamp <= cnt_q;
    end
  end

endmodule

module stamp_chk #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst_n,
  input logic         cnt_en,
  input logic         load_req,
  input logic [W-1:0] load_val,
  input logic         last_smp,
  input logic [W-1:0] cnt_q,
  input logic [W-1:0] stamp,
  input logic         buf_empty
);

  AST_LOAD_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    load_req |=> cnt_q == $past(load_val)); // R4
  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_req && cnt_en) |=> cnt_q == W'($past(cnt_q) + 1'b1)); // R2
  AST_COUNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_req && !cnt_en) |=> $stable(cnt_q)); // R3
  AST_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    last_smp |=> stamp == $past(cnt_q)); // R5
  AST_STAMP_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    !last_smp |=> $stable(stamp)); // R6
  AST_EVT_ON: assert property (@(posedge clk) disable iff (!rst_n)
    last_smp |=> buf_empty); // R7
  AST_EVT_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !last_smp |=> !buf_empty); // R7

endmodule

bind buf_done_stamp stamp_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .load_req(load_req),
  .load_val(load_val), .last_smp(last_smp), .cnt_q(cnt_q),
  .stamp(stamp), .buf_empty(buf_empty)
);

// File: tb/tb_buf_done_stamp.sv
`timescale 1ns/100ps
module tb_buf_done_stamp;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cnt_en = 1'b0;
  logic        load_req = 1'b0;
  logic [31:0] load_val = '0;
  logic        last_smp = 1'b0;
  logic        pwr_down = 1'b0;
  logic [31:0] stamp;
  logic        buf_empty;

  int n_chk = 0;
  int n_bad = 0;

  buf_done_stamp dut (
    .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .load_req(load_req),
    .load_val(load_val), .last_smp(last_smp), .pwr_down(pwr_down),
    .stamp(stamp), .buf_empty(buf_empty)
  );

  always #2.5 clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_load(input logic [31:0] v);
    load_req = 1'b1; load_val = v;
    @(negedge clk);
    load_req = 1'b0;
  endtask

  task automatic grab(output logic [31:0] s, output logic e);
    last_smp = 1'b1;
    @(negedge clk);
    s = stamp; e = buf_empty;
    last_smp = 1'b0;
  endtask

  task automatic t_reset;
    logic [31:0] s; logic e;
    check("R1 stamp", stamp, 32'h0);
    check("R1 buf_empty", {31'h0, buf_empty}, 32'h0);
    grab(s, e);
    check("R1 counter", s, 32'h0);
  endtask

  task automatic t_load_hold;
    logic [31:0] s; logic e;
    cnt_en = 1'b0;
    do_load(32'h1234_5678);
    repeat (4) @(negedge clk);
    grab(s, e);
    check("R4/R3 hold after load", s, 32'h1234_5678);
    check("R7 event with stamp", {31'h0, e}, 32'h1);
    @(negedge clk);
    check("R7 one cycle", {31'h0, buf_empty}, 32'h0);
    check("R6 stamp kept", stamp, 32'h1234_5678);
  endtask

  task automatic t_count;
    logic [31:0] s; logic e;
    cnt_en = 1'b1;
    do_load(32'd1000);
    repeat (25) @(negedge clk);
    grab(s, e);
    check("R2 count", s, 32'd1025);
    cnt_en = 1'b0;
  endtask

  task automatic t_load_priority;
    logic [31:0] s; logic e;
    cnt_en = 1'b1;
    do_load(32'd50);
    repeat (3) @(negedge clk);
    do_load(32'd7000);
    grab(s, e);
    check("R4 load beats increment", s, 32'd7000);
    cnt_en = 1'b0;
  endtask

  task automatic t_same_edge;
    logic [31:0] s; logic e;
    cnt_en = 1'b0;
    do_load(32'hAAAA_0000);
    @(negedge clk);
    load_req = 1'b1; load_val = 32'h5555_1111;
    grab(s, e);
    load_req = 1'b0;
    check("R5 pre-load value captured", s, 32'hAAAA_0000);
    grab(s, e);
    check("R5 load then taken", s, 32'h5555_1111);
  endtask

  task automatic t_quiet;
    logic [31:0] keep;
    keep = stamp;
    cnt_en = 1'b1;
    do_load(32'h0F0F_0F0F);
    repeat (6) @(negedge clk);
    check("R6 no capture no change", stamp, keep);
    check("R7 no event", {31'h0, buf_empty}, 32'h0);
    cnt_en = 1'b0;
  endtask

  task automatic t_wrap;
    logic [31:0] s; logic e;
    cnt_en = 1'b1;
    do_load(32'hFFFF_FFFE);
    repeat (3) @(negedge clk);
    grab(s, e);
    check("R9 wrap", s, 32'h0000_0001);
    cnt_en = 1'b0;
  endtask

  task automatic t_pwrdown;
    logic [31:0] s; logic e;
    cnt_en = 1'b1;
    pwr_down = 1'b1;
    do_load(32'd500);
    repeat (10) @(negedge clk);
    grab(s, e);
    check("R8 count in power-down", s, 32'd510);
    check("R8 event in power-down", {31'h0, e}, 32'h1);
    pwr_down = 1'b0;
    cnt_en = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_load_hold();
    t_count();
    t_load_priority();
    t_same_edge();
    t_quiet();
    t_wrap();
    t_pwrdown();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #100000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule